// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Sine Synthesizer

This block is a direct digital synthesizer that makes two digital sine waves at the same frequency. The angle between them is programmable in whole degrees. One phase accumulator is shared by both channels and adds a frequency tuning word on every clock. Channel A reads its phase from the top bits of the accumulator. Channel B adds a fixed phase offset to the accumulator before taking the top bits. The hardware converts the degree setting into accumulator units with a constant multiply and rounding.

Each channel's phase addresses a quarter-wave magnitude table. Quadrant logic mirrors the address and flips the sign to rebuild the full cycle. The samples come out as registered two's-complement words. A new tuning word and a new degree offset are taken together on a single load strobe, so both take effect on the same edge. Because of this, the relative phase never passes through an intermediate value. A downstream converter takes the two sample words while the valid flag is high.

Top module: `dual_phase_dds`

## Requirements
- R1: The 32-bit phase accumulator adds the captured tuning word on every clock edge outside reset and wraps modulo 2^32. Channel A's table phase is accumulator bits [31:22].
- R2: The quarter table has 256 entries. Entry i is round(4095 * sin(pi*(2i+1)/1024)). For a 10-bit phase p, with quadrant q = p[9:8] and low part a = p[7:0], the magnitude is entry a when q[0]=0 and entry 255-a when q[0]=1. The 13-bit two's-complement sample is that magnitude when q[1]=0 and its negation when q[1]=1.
- R3: Channel B's phase is bits [31:22] of (accumulator + D) mod 2^32, where D = round(deg * 2^32 / 360) for the captured degree value deg.
- R4: A degree input of 360 or more is treated as 359.
- R5: The tuning word and degree inputs are captured only on an edge where load is 1. At all other edges, changes on these inputs have no effect on either output.
- R6: A captured tuning word is first added at the edge after the load edge. The new offset is applied to channel B from the load edge onward, so both settings change together with no mixed intermediate state.
- R7: Both channels have the same latency. The accumulator value present after edge k appears on both sample outputs after edge k+2.
- R8: While rst_n is low at a clock edge, the accumulator, the captured tuning word and the captured offset clear to zero. Both samples read 0 and samp_valid reads 0.
- R9: samp_valid goes to 1 after the second clock edge with rst_n high and stays at 1 until the next reset. While it is 0, both samples read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tune_word | input | 32 | Frequency tuning word, taken on load |
| phase_deg | input | 9 | Channel B offset in whole degrees, taken on load |
| load | input | 1 | Capture strobe for tune_word and phase_deg |
| samp_a | output | 13 | Channel A sample, two's complement |
| samp_b | output | 13 | Channel B sample, two's complement |
| samp_valid | output | 1 | High once both sample pipelines hold real data |

## Verification
Results are due at different delays after a stimulus:

| Stimulus | Result | Due |
|---|---|---|
| Load edge | New offset appears on channel B | Two edges later |
| Load edge | New tuning word shows in the accumulator | One edge later |
| Load edge | New tuning word shows in the samples | Three edges later |
| Release of reset | samp_valid rises | Second edge |

The bench keeps a cycle model that is updated at each rising edge from the inputs held stable since the previous falling edge. The model carries the accumulator, the captured settings and a two-deep phase pipeline. Every output is compared on the falling edge against that model. As a result, each check samples exactly the cycle in which the register chain delivers its result.

// File: rtl/dds_pkg.sv
// Shared constants and elaboration-time helpers for the dual-phase synthesizer.
// Assumes the accumulator is at most 40 bits so that the degree conversion
// constant fits in 64 bits.
package dds_pkg;

    // Fraction bits kept in the degree-to-phase conversion constant.
    localparam int CONV_FRAC = 16;

    // Quarter-wave magnitude for table index idx, centred half a step into the
    // interval, evaluated with a Taylor series at elaboration time.
    function automatic int quarter_sine(input int idx, input int depth, input int amp_max);
        real x;
        real term;
        real s;
        x    = (3.14159265358979323846 / 2.0) * (2.0 * idx + 1.0) / (2.0 * depth);
        term = x;
        s    = x;
        for (int n = 1; n <= 9; n++) begin
            term = -term * x * x / ((2.0 * n) * (2.0 * n + 1.0));
            s    = s + term;
        end
        return $rtoi(amp_max * s + 0.5);
    endfunction

endpackage

// File: rtl/dds_tuning_regs.sv
// Capture registers for the tuning word and the channel B offset.
// The degree input is saturated to 359 and converted to accumulator units
// as round(deg * 2^ACC_W / 360) with a constant multiply. Both registers
// update on the same edge, and only when load is high.
module dds_tuning_regs #(
    parameter int ACC_W = 32,
    parameter int DEG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] tune_word,
    input  logic [DEG_W-1:0] phase_deg,
    output logic [ACC_W-1:0] ftw_q,
    output logic [ACC_W-1:0] off_q
);
    import dds_pkg::*;

    localparam int          DEG_LIMIT = 359;
    localparam logic [63:0] DEG_K     = ((64'd1 << (ACC_W + CONV_FRAC)) + 64'd180) / 64'd360;
    localparam logic [63:0] HALF_LSB  = 64'd1 << (CONV_FRAC - 1);
    localparam logic [63:0] MAX_PROD  = 64'(DEG_LIMIT) * DEG_K + HALF_LSB;
    localparam logic [ACC_W-1:0] OFF_MAX = ACC_W'(MAX_PROD >> CONV_FRAC);

    logic [DEG_W-1:0] deg_sat;
    logic [63:0]      prod;
    logic [ACC_W-1:0] off_next;

    // Clamp out-of-range degree requests to the last whole degree.
    always_comb begin
        deg_sat = (phase_deg > DEG_W'(DEG_LIMIT)) ? DEG_W'(DEG_LIMIT) : phase_deg;
    end

    // Scale degrees to phase units with rounding.
    always_comb begin
        prod     = 64'(deg_sat) * DEG_K + HALF_LSB;
        off_next = ACC_W'(prod >> CONV_FRAC);
    end

    // Take both settings together on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw_q <= '0;
            off_q <= '0;
        end else if (load) begin
            ftw_q <= tune_word;
            off_q <= off_next;
        end
    end

    a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> ($stable(ftw_q) && $stable(off_q)))
        else $error("settings changed without a load strobe");

    a_r4_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        off_q <= OFF_MAX)
        else $error("captured offset exceeds 359 degrees");

endmodule

// File: rtl/dds_phase_acc.sv
// Shared phase accumulator. It adds the captured tuning word every clock and
// wraps naturally at 2^ACC_W. It clears to zero in reset.
module dds_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw,
    output logic [ACC_W-1:0] acc_q
);

    // Advance the phase by one tuning step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + ftw;
        end
    end

    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (acc_q == $past(acc_q) + $past(ftw)))
        else $error("accumulator did not advance by the tuning word");

endmodule

// File: rtl/dds_sine_lut.sv
// Quarter-wave sine lookup with quadrant mirroring, two register stages.
// Stage 1 registers the magnitude read from the mirrored address together
// with the sign. Stage 2 registers the signed sample. It assumes PH_W >= 3.
module dds_sine_lut #(
    parameter int PH_W  = 10,
    parameter int AMP_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PH_W-1:0]        phase,
    output logic signed [AMP_W:0]  sample
);
    import dds_pkg::*;

    localparam int QA_W    = PH_W - 2;
    localparam int DEPTH   = 1 << QA_W;
    localparam int AMP_MAX = (1 << AMP_W) - 1;

    logic [AMP_W-1:0] rom [DEPTH];
    logic [QA_W-1:0]  addr;
    logic [AMP_W-1:0] mag_q;
    logic             neg_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = AMP_W'(quarter_sine(i, DEPTH, AMP_MAX));
    end

    // Mirror the address in the second and fourth quadrants.
    always_comb begin
        addr = phase[PH_W-2] ? ~phase[QA_W-1:0] : phase[QA_W-1:0];
    end

    // Stage 1: read the magnitude and keep the half-cycle sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            neg_q <= 1'b0;
        end else begin
            mag_q <= rom[addr];
            neg_q <= phase[PH_W-1];
        end
    end

    // Stage 2: apply the sign to form the two's-complement sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample <= '0;
        end else if (neg_q) begin
            sample <= -$signed({1'b0, mag_q});
        end else begin
            sample <= $signed({1'b0, mag_q});
        end
    end

    a_r2_sign_follows_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mag_q) != '0) |-> (sample[AMP_W] == $past(neg_q)))
        else $error("sample sign does not follow the upper half-cycle bit");

endmodule

// File: rtl/dual_phase_dds.sv
// Top of the dual-channel synthesizer. One accumulator feeds channel A
// directly. Channel B adds the captured degree offset. Each channel has an
// identical two-stage lookup, so both channels share the same latency. The
// valid flag marks the point where both lookup pipelines hold data.
module dual_phase_dds #(
    parameter int ACC_W = 32,
    parameter int PH_W  = 10,
    parameter int AMP_W = 12,
    parameter int DEG_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ACC_W-1:0]      tune_word,
    input  logic [DEG_W-1:0]      phase_deg,
    input  logic                  load,
    output logic signed [AMP_W:0] samp_a,
    output logic signed [AMP_W:0] samp_b,
    output logic                  samp_valid
);

    localparam int N_CH     = 2;
    localparam int LAT      = 2;
    localparam int PH_SHIFT = ACC_W - PH_W;
    localparam int AMP_MAX  = (1 << AMP_W) - 1;

    logic [ACC_W-1:0]      ftw_q;
    logic [ACC_W-1:0]      off_q;
    logic [ACC_W-1:0]      acc_q;
    logic [PH_W-1:0]       ch_phase [N_CH];
    logic signed [AMP_W:0] ch_samp  [N_CH];
    logic [LAT-1:0]        fill_q;

    dds_tuning_regs #(.ACC_W(ACC_W), .DEG_W(DEG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tune_word (tune_word),
        .phase_deg (phase_deg),
        .ftw_q     (ftw_q),
        .off_q     (off_q)
    );

    dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .ftw   (ftw_q),
        .acc_q (acc_q)
    );

    // Derive each channel's table phase from the shared accumulator.
    always_comb begin
        ch_phase[0] = PH_W'(acc_q >> PH_SHIFT);
        ch_phase[1] = PH_W'((acc_q + off_q) >> PH_SHIFT);
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dds_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
            .clk    (clk),
            .rst_n  (rst_n),
            .phase  (ch_phase[c]),
            .sample (ch_samp[c])
        );
    end

    // Shift in ones after reset to mark when the pipelines are primed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else begin
            fill_q <= {fill_q[LAT-2:0], 1'b1};
        end
    end

    assign samp_a     = ch_samp[0];
    assign samp_b     = ch_samp[1];
    assign samp_valid = fill_q[LAT-1];

    a_r9_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> samp_valid)
        else $error("valid dropped without reset");

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |-> (samp_a == '0 && samp_b == '0))
        else $error("samples nonzero before valid");

    a_r2_nonzero_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> (samp_a != '0 && samp_b != '0 &&
                        samp_a <= AMP_MAX && samp_a >= -AMP_MAX &&
                        samp_b <= AMP_MAX && samp_b >= -AMP_MAX))
        else $error("sample outside the table range");

endmodule

// File: tb/dual_phase_dds_bench.sv
// Self-checking bench. A cycle model updated at each rising edge predicts
// both samples and the valid flag. Every falling edge compares them.
module dual_phase_dds_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [31:0]        tune_word = '0;
    logic [8:0]         phase_deg = '0;
    logic               load = 1'b0;
    logic signed [12:0] samp_a;
    logic signed [12:0] samp_b;
    logic               samp_valid;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R8";

    int             tbl [256];
    logic [31:0]    m_acc, m_ftw, m_off;
    logic [31:0]    m_ph1a, m_ph1b, m_ph2a, m_ph2b;
    int             m_cnt = 0;

    always #10 clk = ~clk;

    dual_phase_dds u_dual_phase_dds (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_word  (tune_word),
        .phase_deg  (phase_deg),
        .load       (load),
        .samp_a     (samp_a),
        .samp_b     (samp_b),
        .samp_valid (samp_valid)
    );

    function automatic logic [31:0] deg_units(input int deg);
        longint unsigned d;
        d = (deg >= 360) ? 359 : deg;
        return 32'(((d << 32) + 180) / 360);
    endfunction

    function automatic logic signed [12:0] exp_samp(input logic [31:0] acc);
        logic [9:0] p;
        int idx;
        p   = acc[31:22];
        idx = p[8] ? 255 - int'(p[7:0]) : int'(p[7:0]);
        return p[9] ? 13'(-tbl[idx]) : 13'(tbl[idx]);
    endfunction

    // Cycle model of the register chain, updated on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '0; m_ftw = '0; m_off = '0;
            m_ph1a = '0; m_ph1b = '0; m_ph2a = '0; m_ph2b = '0;
            m_cnt = 0;
        end else begin
            m_ph2a = m_ph1a;
            m_ph2b = m_ph1b;
            m_ph1a = m_acc;
            m_ph1b = m_acc + m_off;
            m_acc  = m_acc + m_ftw;
            if (load) begin
                m_ftw = tune_word;
                m_off = deg_units(int'(phase_deg));
            end
            if (m_cnt < 3) m_cnt++;
        end
    end

    task automatic check_now();
        logic signed [12:0] ea, eb;
        logic ev;
        ev = (m_cnt >= 2);
        ea = ev ? exp_samp(m_ph2a) : 13'sd0;
        eb = ev ? exp_samp(m_ph2b) : 13'sd0;
        n_tests++;
        if (samp_valid !== ev) begin
            n_fail++;
            $display("FAIL R9 %s: samp_valid=%0b expected %0b", cur_tag, samp_valid, ev);
        end
        n_tests++;
        if (samp_a !== ea) begin
            n_fail++;
            $display("FAIL R7 %s: samp_a=%0d expected %0d", cur_tag, samp_a, ea);
        end
        n_tests++;
        if (samp_b !== eb) begin
            n_fail++;
            $display("FAIL R3 %s: samp_b=%0d expected %0d", cur_tag, samp_b, eb);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic do_load(input logic [31:0] tw, input int deg);
        tune_word = tw;
        phase_deg = 9'(deg);
        load      = 1'b1;
        tick(1);
        load      = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++)
            tbl[i] = $rtoi(4095.0 * $sin(3.14159265358979323846 * (2.0 * i + 1.0) / 1024.0) + 0.5);

        // R8: reset state; R9: valid timing after release.
        cur_tag = "R8";
        tick(4);
        rst_n = 1'b1;
        cur_tag = "R9";
        tick(4);

        // R1 R2: one table step per clock sweeps all 1024 phases.
        cur_tag = "R2";
        do_load(32'h0040_0000, 0);
        tick(1100);

        // R3 R4 R6: every degree 0..511 with a non-aligned step.
        cur_tag = "R4";
        for (int d = 0; d < 512; d++) begin
            do_load(32'h0040_3039, d);
            tick(3);
        end

        // R1: large step wraps the accumulator backwards.
        cur_tag = "R1";
        do_load(32'hFFC0_0001, 90);
        tick(600);

        // R5: input changes without a load have no effect.
        cur_tag = "R5";
        for (int i = 0; i < 60; i++) begin
            tune_word = 32'h1234_5678 * (i + 1);
            phase_deg = 9'(i * 7);
            tick(1);
        end

        // R6: frozen accumulator exposes the offset directly.
        cur_tag = "R6";
        do_load(32'h0000_0000, 180);
        tick(5);
        do_load(32'h0000_0000, 400);
        tick(5);

        // R8: reset in the middle of a run.
        cur_tag = "R8";
        do_load(32'h0123_4567, 45);
        tick(20);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        cur_tag = "R9";
        tick(40);

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

endmodule